// File: doc/BRIEF.md
# In-Flight Instruction Queue with Speculation Tracking

This block keeps one entry for every instruction between dispatch and architectural completion, held in program order in a circular queue. Dispatch claims entries at the tail and receives their indices. Execution units then report status changes by index. A branch-resolution port names one speculative region and says whether its prediction held. The head retires finished, non-speculative work in order and presents the destination rename register of each retired instruction. Entries on a mispredicted path are marked invalid. When an invalid entry reaches the head, it leaves without a commit.

Downstream logic uses each commit slot to copy a rename register into architectural state and to free it. The queue does neither of these. Dispatch watches the ready output and holds back while it is low. Head and tail pointers each carry one extra wrap bit, so a full queue and an empty queue can be told apart without a separate counter.

Top module: `inflight_queue`

## Requirements
- R1: Request slots are used lowest first and must be contiguous from slot 0. When a request is accepted, slot i is given entry index (tail + i) mod DEPTH, and the tail advances by the number of slots requested.
- R2: `alloc_rdy` is high exactly when at least ALLOC_W entries are free. The free count is taken from the registered pointers, before any completion in the same cycle. While `alloc_rdy` is low, requests are ignored and the tail does not move.
- R3: A status update writes a 2-bit state into the indexed entry on the next edge. The states are 0 = waiting, 1 = executing and 2 = finished. When two ports name the same index, the higher-numbered port wins. A newly allocated entry starts in state 0.
- R4: A new entry stores its region mask from `alloc_spec`. If a resolution arrives in the same cycle, it applies to the incoming mask as well: a correct resolution clears that bit, and a wrong one also marks the entry invalid.
- R5: A correct resolution clears the named region bit (one-hot `br_mask`) in every entry. An entry whose mask becomes all zero is non-speculative.
- R6: A wrong resolution marks invalid every entry whose mask has the named bit set, and then clears that bit.
- R7: An entry is eligible to complete when it is finished with an all-zero mask. Each cycle the queue removes up to CMPL_W consecutive eligible or invalid entries from the head. `cmt_vld[i]` flags slot i as a real commit.
- R8: An invalid entry at the head is removed in whatever state it is in, without `cmt_vld`. It uses up one slot of the per-cycle width, so a valid entry behind it can commit in the next slot of the same cycle.
- R9: After reset the queue is empty, `alloc_rdy` is high and no `cmt_vld` bit is set.
- R10: `cmt_dst` slot i carries the destination rename register that was written at allocation into the entry being committed in slot i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | ALLOC_W | Allocation request per dispatch slot, contiguous from bit 0 |
| alloc_dst | input | ALLOC_W*TAG_W | Destination rename register per slot |
| alloc_spec | input | ALLOC_W*NBR | Speculative region mask per slot |
| alloc_rdy | output | 1 | At least ALLOC_W entries are free |
| alloc_idx | output | ALLOC_W*IDX_W | Entry index per slot |
| upd_vld | input | UPD_W | Status update valid per port |
| upd_idx | input | UPD_W*IDX_W | Entry index per update port |
| upd_st | input | UPD_W*2 | New state per port (0 wait, 1 exec, 2 done) |
| br_vld | input | 1 | Branch resolution valid |
| br_mask | input | NBR | One-hot region being resolved |
| br_ok | input | 1 | 1 = prediction correct, 0 = mispredicted |
| cmt_vld | output | CMPL_W | Architectural commit per completion slot |
| cmt_dst | output | CMPL_W*TAG_W | Rename register committed per slot |

## Verification
Directed sequences come first. The queue is filled until allocation stalls, to separate the free-count threshold from pointer wrap. Entries are finished out of order, to show that a finished entry behind an unfinished head waits. Runs of finished entries longer than the completion width show the per-cycle cap. Speculative entries are retired by a correct resolution and squashed by a wrong one. An invalid entry is placed directly ahead of a valid one, to show that squashed slots take part of the width. A resolution in the same cycle as an allocation checks that incoming masks are filtered. A long pseudo-random sweep then mixes allocation, updates and resolutions across many wraps, and compares every cycle's ready flag, indices and commits against an arithmetic model of the queue.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_EXEC = 2'd1,
    ST_DONE = 2'd2
  } exec_st_e;
endpackage

// File: rtl/iq_rst_sync.sv
module iq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/iq_tail_ctl.sv
module iq_tail_ctl #(
  parameter int DEPTH   = 8,
  parameter int ALLOC_W = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic [PTR_W-1:0]         head_q,
  input  logic [PTR_W-1:0]         tail_q,
  input  logic [ALLOC_W-1:0]       alloc_req,
  input  logic                     alloc_en,
  output logic                     room_ok,
  output logic [PTR_W-1:0]         tail_nxt,
  output logic [ALLOC_W*IDX_W-1:0] slot_idx
);
  logic [PTR_W-1:0] used;
  logic [PTR_W-1:0] n_req;

  always_comb begin
    used    = tail_q - head_q;
    room_ok = (PTR_W'(DEPTH) - used) >= PTR_W'(ALLOC_W);
    n_req   = '0;
    for (int i = 0; i < ALLOC_W; i++) begin
      n_req = n_req + PTR_W'(alloc_req[i]);
    end
    tail_nxt = alloc_en ? (tail_q + n_req) : tail_q;
  end

  for (genvar i = 0; i < ALLOC_W; i++) begin : g_idx
    assign slot_idx[i*IDX_W +: IDX_W] = tail_q[IDX_W-1:0] + IDX_W'(i);
  end
endmodule

// File: rtl/iq_head_scan.sv
module iq_head_scan
  import iq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CMPL_W = 2,
  parameter int TAG_W  = 6,
  parameter int NBR    = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [PTR_W-1:0]            head_q,
  input  logic [PTR_W-1:0]            tail_q,
  input  logic [DEPTH-1:0][1:0]       st_q,
  input  logic [DEPTH-1:0]            inv_q,
  input  logic [DEPTH-1:0][NBR-1:0]   spec_q,
  input  logic [DEPTH-1:0][TAG_W-1:0] dst_q,
  output logic [CMPL_W-1:0]           cmt_vld,
  output logic [CMPL_W*TAG_W-1:0]     cmt_dst,
  output logic [PTR_W-1:0]            head_nxt
);
  logic [PTR_W-1:0] used;
  logic [PTR_W-1:0] n_pop;
  logic [IDX_W-1:0] e;
  logic             elig;
  logic             run;

  always_comb begin
    used  = tail_q - head_q;
    run   = 1'b1;
    n_pop = '0;
    e     = '0;
    elig  = 1'b0;
    for (int i = 0; i < CMPL_W; i++) begin
      e    = head_q[IDX_W-1:0] + IDX_W'(i);
      elig = (PTR_W'(i) < used) &&
             (inv_q[e] || ((st_q[e] == ST_DONE) && (spec_q[e] == '0)));
      run  = run & elig;
      cmt_vld[i] = run & ~inv_q[e];
      cmt_dst[i*TAG_W +: TAG_W] = dst_q[e];
      n_pop = n_pop + PTR_W'(run);
    end
    head_nxt = head_q + n_pop;
  end
endmodule

// File: rtl/inflight_queue.sv
module inflight_queue
  import iq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ALLOC_W = 2,
  parameter int UPD_W   = 2,
  parameter int CMPL_W  = 2,
  parameter int TAG_W   = 6,
  parameter int NBR     = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ALLOC_W-1:0]       alloc_req,
  input  logic [ALLOC_W*TAG_W-1:0] alloc_dst,
  input  logic [ALLOC_W*NBR-1:0]   alloc_spec,
  output logic                     alloc_rdy,
  output logic [ALLOC_W*IDX_W-1:0] alloc_idx,
  input  logic [UPD_W-1:0]         upd_vld,
  input  logic [UPD_W*IDX_W-1:0]   upd_idx,
  input  logic [UPD_W*2-1:0]       upd_st,
  input  logic                     br_vld,
  input  logic [NBR-1:0]           br_mask,
  input  logic                     br_ok,
  output logic [CMPL_W-1:0]        cmt_vld,
  output logic [CMPL_W*TAG_W-1:0]  cmt_dst
);
  logic                      rst_q_n;
  logic                      room_ok;
  logic [PTR_W-1:0]          head_q, head_nxt;
  logic [PTR_W-1:0]          tail_q, tail_nxt;
  logic [DEPTH-1:0][1:0]     st_q, st_d;
  logic [DEPTH-1:0]          inv_q, inv_d;
  logic [DEPTH-1:0][NBR-1:0] spec_q, spec_d;
  logic [DEPTH-1:0][TAG_W-1:0] dst_q, dst_d;
  logic [IDX_W-1:0]          slot;
  logic [NBR-1:0]            new_spec;
  logic                      dst_en;

  iq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign alloc_rdy = room_ok & rst_q_n;
  assign dst_en    = alloc_rdy & (|alloc_req);

  iq_tail_ctl #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W)) u_tail (
    .head_q    (head_q),
    .tail_q    (tail_q),
    .alloc_req (alloc_req),
    .alloc_en  (alloc_rdy),
    .room_ok   (room_ok),
    .tail_nxt  (tail_nxt),
    .slot_idx  (alloc_idx)
  );

  iq_head_scan #(.DEPTH(DEPTH), .CMPL_W(CMPL_W), .TAG_W(TAG_W), .NBR(NBR)) u_head (
    .head_q   (head_q),
    .tail_q   (tail_q),
    .st_q     (st_q),
    .inv_q    (inv_q),
    .spec_q   (spec_q),
    .dst_q    (dst_q),
    .cmt_vld  (cmt_vld),
    .cmt_dst  (cmt_dst),
    .head_nxt (head_nxt)
  );

  // Next-state: resolution on resident entries, then status writes, then new entries.
  always_comb begin
    st_d     = st_q;
    inv_d    = inv_q;
    spec_d   = spec_q;
    dst_d    = dst_q;
    slot     = '0;
    new_spec = '0;
    if (br_vld) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (!br_ok && ((spec_q[e] & br_mask) != '0)) inv_d[e] = 1'b1;
        spec_d[e] = spec_q[e] & ~br_mask;
      end
    end
    for (int j = 0; j < UPD_W; j++) begin
      if (upd_vld[j]) st_d[upd_idx[j*IDX_W +: IDX_W]] = upd_st[j*2 +: 2];
    end
    for (int i = 0; i < ALLOC_W; i++) begin
      if (alloc_rdy && alloc_req[i]) begin
        slot        = alloc_idx[i*IDX_W +: IDX_W];
        new_spec    = alloc_spec[i*NBR +: NBR];
        st_d[slot]  = ST_WAIT;
        dst_d[slot] = alloc_dst[i*TAG_W +: TAG_W];
        inv_d[slot] = br_vld && !br_ok && ((new_spec & br_mask) != '0);
        spec_d[slot] = br_vld ? (new_spec & ~br_mask) : new_spec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      head_q <= '0;
      tail_q <= '0;
      st_q   <= '0;
      inv_q  <= '0;
      spec_q <= '0;
    end else begin
      head_q <= head_nxt;
      tail_q <= tail_nxt;
      st_q   <= st_d;
      inv_q  <= inv_d;
      spec_q <= spec_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dst_en) dst_q <= dst_d;
  end
endmodule

// File: rtl/inflight_queue_chk.sv
module inflight_queue_chk #(
  parameter int DEPTH   = 8,
  parameter int ALLOC_W = 2,
  parameter int CMPL_W  = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic [ALLOC_W-1:0] alloc_req,
  input logic               alloc_rdy,
  input logic [CMPL_W-1:0]  cmt_vld,
  input logic [PTR_W-1:0]   head_q,
  input logic [PTR_W-1:0]   tail_q
);
  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    alloc_rdy |=> tail_q == $past(tail_q) + PTR_W'($countones($past(alloc_req)))); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !alloc_rdy |=> tail_q == $past(tail_q)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    PTR_W'(tail_q - head_q) <= PTR_W'(DEPTH)); // R2

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tail_q == head_q) |-> cmt_vld == '0); // R7

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tail_q == head_q) |=> $stable(head_q)); // R8

  AST_CMT_ADV: assert property (@(posedge clk) disable iff (!rst_q_n)
    cmt_vld[0] |=> head_q != $past(head_q)); // R7
endmodule

bind inflight_queue inflight_queue_chk #(
  .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .CMPL_W(CMPL_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .alloc_req (alloc_req),
  .alloc_rdy (alloc_rdy),
  .cmt_vld   (cmt_vld),
  .head_q    (head_q),
  .tail_q    (tail_q)
);

// File: tb/sim_inflight_queue.sv
`timescale 1ns/1ps
module sim_inflight_queue;
  localparam int DEPTH = 8, AW = 2, UW = 2, CW = 2, TW = 6, NB = 4, IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [AW-1:0]    alloc_req;
  logic [AW*TW-1:0] alloc_dst;
  logic [AW*NB-1:0] alloc_spec;
  logic             alloc_rdy;
  logic [AW*IW-1:0] alloc_idx;
  logic [UW-1:0]    upd_vld;
  logic [UW*IW-1:0] upd_idx;
  logic [UW*2-1:0]  upd_st;
  logic             br_vld;
  logic [NB-1:0]    br_mask;
  logic             br_ok;
  logic [CW-1:0]    cmt_vld;
  logic [CW*TW-1:0] cmt_dst;

  inflight_queue #(.DEPTH(DEPTH), .ALLOC_W(AW), .UPD_W(UW), .CMPL_W(CW),
                   .TAG_W(TW), .NBR(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_dst(alloc_dst),
    .alloc_spec(alloc_spec), .alloc_rdy(alloc_rdy), .alloc_idx(alloc_idx),
    .upd_vld(upd_vld), .upd_idx(upd_idx), .upd_st(upd_st), .br_vld(br_vld),
    .br_mask(br_mask), .br_ok(br_ok), .cmt_vld(cmt_vld), .cmt_dst(cmt_dst));

  int nchk = 0, nfail = 0;
  int mh, mt;
  logic [1:0]    mst [DEPTH];
  logic [NB-1:0] msp [DEPTH];
  logic          minv[DEPTH];
  logic [TW-1:0] mdst[DEPTH];
  logic [31:0]   lf = 32'h1234_5678;
  int b;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    alloc_req = '0; alloc_dst = '0; alloc_spec = '0;
    upd_vld = '0; upd_idx = '0; upd_st = '0;
    br_vld = 1'b0; br_mask = '0; br_ok = 1'b0;
  endtask

  task automatic put(int s, int d, logic [NB-1:0] sp);
    alloc_req[s] = 1'b1;
    alloc_dst[s*TW +: TW] = TW'(d);
    alloc_spec[s*NB +: NB] = sp;
  endtask

  task automatic mark(int p, int idx, int st);
    upd_vld[p] = 1'b1;
    upd_idx[p*IW +: IW] = IW'(idx % DEPTH);
    upd_st[p*2 +: 2] = 2'(st);
  endtask

  task automatic resolve(logic [NB-1:0] m, logic ok);
    br_vld = 1'b1; br_mask = m; br_ok = ok;
  endtask

  // Compare outputs with the model, clock once, advance the model.
  task automatic step(string tag);
    int cnt, npop, e;
    bit rdy, run, el, ev;
    #2;
    cnt = mt - mh;
    rdy = (DEPTH - cnt) >= AW;
    chk({tag, " alloc_rdy"}, int'(alloc_rdy), int'(rdy));
    for (int i = 0; i < AW; i++)
      if (alloc_req[i] && rdy)
        chk({tag, " alloc_idx"}, int'(alloc_idx[i*IW +: IW]), (mt + i) % DEPTH);
    npop = 0; run = 1'b1;
    for (int i = 0; i < CW; i++) begin
      e  = (mh + i) % DEPTH;
      el = (i < cnt) && (minv[e] || (mst[e] == 2'd2 && msp[e] == '0));
      run = run && el;
      ev = run && !minv[e];
      chk({tag, " cmt_vld"}, int'(cmt_vld[i]), int'(ev));
      if (ev) chk({tag, " cmt_dst"}, int'(cmt_dst[i*TW +: TW]), int'(mdst[e]));
      if (run) npop++;
    end
    @(posedge clk);
    if (br_vld)
      for (int k = 0; k < DEPTH; k++) begin
        if (!br_ok && (msp[k] & br_mask) != '0) minv[k] = 1'b1;
        msp[k] = msp[k] & ~br_mask;
      end
    for (int j = 0; j < UW; j++)
      if (upd_vld[j]) mst[upd_idx[j*IW +: IW]] = upd_st[j*2 +: 2];
    if (rdy)
      for (int i = 0; i < AW; i++)
        if (alloc_req[i]) begin
          e = (mt + i) % DEPTH;
          mst[e]  = 2'd0;
          mdst[e] = alloc_dst[i*TW +: TW];
          minv[e] = br_vld && !br_ok && ((alloc_spec[i*NB +: NB] & br_mask) != '0);
          msp[e]  = br_vld ? (alloc_spec[i*NB +: NB] & ~br_mask) : alloc_spec[i*NB +: NB];
        end
    mh += npop;
    if (rdy) mt += int'(alloc_req[0]) + int'(alloc_req[1]);
    @(negedge clk);
    clr();
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    clr();
    rst_n = 1'b0;
    mh = 0; mt = 0;
    for (int k = 0; k < DEPTH; k++) begin
      mst[k] = '0; msp[k] = '0; minv[k] = 1'b0; mdst[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: empty, ready, no commits
    chk("R9 cmt_vld after reset", int'(cmt_vld), 0);
    step("R9");

    // R1: fill in pairs; R2: full queue stalls and ignores requests
    for (int k = 0; k < 4; k++) begin
      put(0, 10 + 2*k, '0); put(1, 11 + 2*k, '0);
      step("R1");
    end
    put(0, 50, '0); put(1, 51, '0);
    step("R2");
    step("R2");

    // R3: out-of-order finish holds the head; then in-order drain 2 per cycle (R7)
    mark(0, 1, 2); step("R3");
    mark(0, 0, 1); step("R3");
    mark(0, 0, 2); step("R3");
    step("R7");
    mark(0, 2, 2); mark(1, 3, 2); step("R3");
    mark(0, 4, 2); mark(1, 5, 2); step("R7");
    mark(0, 6, 1); mark(1, 6, 2); step("R3");
    mark(0, 7, 2); step("R7");
    step("R7");
    step("R7");

    // R4/R5: speculative entries wait until a correct resolution
    b = mt;
    put(0, 20, 4'b0001); put(1, 21, 4'b0001); step("R4");
    mark(0, b, 2); mark(1, b + 1, 2); step("R3");
    step("R5");
    resolve(4'b0001, 1'b1); step("R5");
    step("R5");
    step("R5");

    // R6/R8: wrong path squashed; invalid slot shares the width with a commit
    b = mt;
    put(0, 30, '0); put(1, 31, 4'b0010); step("R6");
    put(0, 32, 4'b0010); put(1, 33, '0); step("R6");
    mark(0, b, 2); mark(1, b + 3, 2); step("R6");
    resolve(4'b0010, 1'b0); step("R6");
    step("R8");
    step("R8");
    step("R8");

    // R4: resolution in the allocation cycle filters the incoming mask
    b = mt;
    put(0, 40, 4'b0100); put(1, 41, 4'b1000); resolve(4'b0100, 1'b0); step("R4");
    mark(0, b + 1, 2); step("R4");
    step("R4");
    resolve(4'b1000, 1'b1); step("R5");
    step("R5");
    step("R10");

    // Sweep: pseudo-random mix across many wraps (R7, R10)
    for (int n = 0; n < 3000; n++) begin
      int cnt, na;
      logic [31:0] r;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      r = lf;
      cnt = mt - mh;
      na = int'(r[1:0]) % 3;
      if (na >= 1) put(0, int'(r[13:8]), r[3] ? NB'(1) << r[5:4] : '0);
      if (na == 2) put(1, int'(r[19:14]), r[6] ? NB'(1) << r[21:20] : '0);
      if (cnt > 0) begin
        if (r[22]) mark(0, mh + int'(r[27:24]) % cnt, r[23] ? 2 : int'(r[28]));
        if (r[29]) mark(1, mh + int'(r[11:9]) % cnt, 2);
      end
      if (r[31:30] == 2'b00) resolve(NB'(1) << r[17:16], r[2]);
      step(n[0] ? "R10" : "R7");
    end

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule